// File: doc/BRIEF.md
# Dual-Mode PWM Channel Counter

This block is one pulse-width-modulated output channel. An 8-bit counter moves one step each time an external tick strobe arrives while the channel is enabled. It runs either as a sawtooth, giving an edge-aligned waveform, or as a triangle, giving a symmetric waveform. The output is active while the count is below the duty value. A polarity input chooses whether the active level is high or low.

Period and duty are double-buffered. Software writes new values into buffer registers through a small register port. The channel copies them into its working copies at the end of a period, while it is disabled, or at once when software writes the counter. Writing the counter restarts the channel from zero, whatever data is written. Reading any register has no side effect. A two-stage synchronizer releases the asynchronous reset.

Top module: `pwm_chan_counter`

## Requirements
- R1: The counter changes only on a clock edge where `tick` and `chan_en` are both 1, and by one step per such edge; with `tick` low it holds.
- R2: With `center_mode`=0 and working period P>0, the count goes 0,1,...,P-1 and then back to 0, so one output period lasts P ticks.
- R3: With `center_mode`=1 and working period P>0, the count rises from 0 to P, falls back to 0 and repeats, so one output period lasts 2P ticks.
- R4: A register write to address 0 (counter), whatever its data, sets the count to 0 and the direction to up on the next edge; it overrides `tick` and `chan_en`.
- R5: A counter write copies both buffers into the working period and duty on the same edge.
- R6: After a counter write the output sits at the active level (high when `pol_hi`=1, low when `pol_hi`=0) until the next tick.
- R7: While `chan_en`=0 the count and the output hold their values; when re-enabled, counting resumes from the held count.
- R8: `reg_rdata` is combinational from `reg_addr`: 0 = count, 1 = period buffer, 2 = duty buffer, 3 = zero; reading changes nothing.
- R9: A buffer write takes effect only at the end of the running period (or on a counter write or while disabled); the current period finishes with the old values.
- R10: On every tick the output level is recomputed as active when the new count is below the working duty D. In edge mode this gives D active ticks per period; in triangle mode it gives 2D-1 active ticks (for 0<D<P).
- R11: A duty at or above the period gives a constantly active output; a period of 0 gives a constantly active output with the count held at 0.
- R12: After reset the count, direction, both buffers and both working copies are 0, and the output is at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe from the clock selector |
| chan_en | input | 1 | Channel enable |
| pol_hi | input | 1 | 1: active level high; 0: active level low |
| center_mode | input | 1 | 0: edge-aligned; 1: center-aligned |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 count, 1 period buffer, 2 duty buffer) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
The bench hits the turnaround at the top of the triangle. A design that wraps there instead of reversing reads 0 where P is expected and halves the period. It writes the counter while the triangle is falling. A design that keeps the down direction would fall from 0 and read 0 instead of 1 after the next tick. It changes the duty buffer in mid-period. A design without double buffering would switch the output early, at a count where the old duty still applies. It also checks that disabling freezes the count rather than clearing it, and that zero period and duty at or above period stay constantly active instead of glitching at the wrap.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  // Register port addresses
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_NONE   = 2'd3
  } pwm_reg_e;

  // Counting direction (used in center-aligned mode)
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

endpackage

// File: rtl/pwm_dbl_buf.sv
module pwm_dbl_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_per,
  input  logic         wr_duty,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] per_buf,
  output logic [W-1:0] duty_buf,
  output logic [W-1:0] per_act,
  output logic [W-1:0] duty_act,
  output logic [W-1:0] per_nxt,
  output logic [W-1:0] duty_nxt
);

  logic [W-1:0] per_buf_q,  per_buf_d;
  logic [W-1:0] duty_buf_q, duty_buf_d;
  logic [W-1:0] per_act_q,  per_act_d;
  logic [W-1:0] duty_act_q, duty_act_d;

  // Next state: buffers take writes, working copies take buffers on load
  always_comb begin
    per_buf_d  = per_buf_q;
    duty_buf_d = duty_buf_q;
    if (wr_per)  per_buf_d  = wdata;
    if (wr_duty) duty_buf_d = wdata;
    per_act_d  = per_act_q;
    duty_act_d = duty_act_q;
    if (load) begin
      per_act_d  = per_buf_q;
      duty_act_d = duty_buf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf_q  <= '0;
      duty_buf_q <= '0;
      per_act_q  <= '0;
      duty_act_q <= '0;
    end else begin
      per_buf_q  <= per_buf_d;
      duty_buf_q <= duty_buf_d;
      per_act_q  <= per_act_d;
      duty_act_q <= duty_act_d;
    end
  end

  assign per_buf  = per_buf_q;
  assign duty_buf = duty_buf_q;
  assign per_act  = per_act_q;
  assign duty_act = duty_act_q;
  assign per_nxt  = per_act_d;
  assign duty_nxt = duty_act_d;

  // R9: working copies move only on a load
  assert_hold_working_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(per_act_q) && $stable(duty_act_q)));

  // R5: a load brings in the buffer contents of that cycle
  assert_load_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (per_act_q == $past(per_buf_q) && duty_act_q == $past(duty_buf_q)));

endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  logic         center,
  input  logic [W-1:0] per_act,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         dir_down,
  output logic         period_end
);

  localparam int          W1   = W + 1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  cnt_dir_e     dir_q, dir_d;
  logic [W1-1:0] up_wide;
  logic [W1-1:0] per_wide;

  assign up_wide  = {1'b0, cnt_q} + W1'(1);
  assign per_wide = {1'b0, per_act};

  always_comb begin
    cnt_d      = cnt_q;
    dir_d      = dir_q;
    period_end = 1'b0;
    if (clr) begin
      cnt_d = '0;
      dir_d = CNT_UP;
    end else if (step) begin
      if (per_act == '0) begin
        cnt_d      = '0;
        dir_d      = CNT_UP;
        period_end = 1'b1;
      end else if (!center) begin
        if (up_wide >= per_wide) begin
          cnt_d      = '0;
          dir_d      = CNT_UP;
          period_end = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (dir_q == CNT_UP) begin
        if (cnt_q < per_act) begin
          cnt_d = cnt_q + ONE;
          if (up_wide >= per_wide) dir_d = CNT_DOWN;
        end else begin
          cnt_d = cnt_q - ONE;
          dir_d = CNT_DOWN;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d      = '0;
          dir_d      = CNT_UP;
          period_end = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= CNT_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt      = cnt_q;
  assign cnt_nxt  = cnt_d;
  assign dir_down = (dir_q == CNT_DOWN);

  // R4: counter write clears count and direction
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && dir_q == CNT_UP));

  // R1 / R7: without a step the count holds
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt_q));

  // R2: edge mode wraps after P-1
  assert_left_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !center && per_act != '0 && cnt_q == per_act - ONE) |=> (cnt_q == '0));

  // R3: triangle reverses at the top
  assert_center_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && center && dir_q == CNT_UP && per_act != '0 && up_wide == per_wide)
    |=> (cnt_q == per_act && dir_q == CNT_DOWN));

  // R3: triangle ends the period at zero and turns up
  assert_center_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && center && dir_q == CNT_DOWN && cnt_q == ONE && per_act != '0)
    |=> (cnt_q == '0 && dir_q == CNT_UP));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] per_nxt,
  input  logic [W-1:0] duty_nxt,
  input  logic         pol_hi,
  output logic         pwm_out
);

  logic act_q, act_d;
  logic lvl;

  always_comb begin
    lvl   = (per_nxt == '0) || (duty_nxt >= per_nxt) || (cnt_nxt < duty_nxt);
    act_d = act_q;
    if (clr)       act_d = 1'b1;
    else if (step) act_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign pwm_out = pol_hi ? act_q : ~act_q;

  // R6: counter write forces the active level
  assert_write_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> act_q);

  // R11: zero period keeps the output active
  assert_zero_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && per_nxt == '0) |=> act_q);

  // R7: no step, no change
  assert_hold_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(act_q));

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
  import pwm_chan_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         chan_en,
  input  logic         pol_hi,
  input  logic         center_mode,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         pwm_out
);

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_i = rst_pipe[SYNC_STAGES-1];

  // Register decode
  logic cnt_wr, per_wr, duty_wr;
  assign cnt_wr  = reg_wr && (reg_addr == REG_COUNT);
  assign per_wr  = reg_wr && (reg_addr == REG_PERIOD);
  assign duty_wr = reg_wr && (reg_addr == REG_DUTY);

  logic         step, period_end, load, dir_down;
  logic [W-1:0] cnt, cnt_nxt;
  logic [W-1:0] per_buf, duty_buf, per_act, duty_act, per_nxt, duty_nxt;

  assign step = tick && chan_en;
  assign load = cnt_wr || !chan_en || (step && period_end);

  pwm_dbl_buf #(.W(W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_per   (per_wr),
    .wr_duty  (duty_wr),
    .wdata    (reg_wdata),
    .load     (load),
    .per_buf  (per_buf),
    .duty_buf (duty_buf),
    .per_act  (per_act),
    .duty_act (duty_act),
    .per_nxt  (per_nxt),
    .duty_nxt (duty_nxt)
  );

  pwm_cnt_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .step       (step),
    .clr        (cnt_wr),
    .center     (center_mode),
    .per_act    (per_act),
    .cnt        (cnt),
    .cnt_nxt    (cnt_nxt),
    .dir_down   (dir_down),
    .period_end (period_end)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (cnt_wr),
    .step     (step),
    .cnt_nxt  (cnt_nxt),
    .per_nxt  (per_nxt),
    .duty_nxt (duty_nxt),
    .pol_hi   (pol_hi),
    .pwm_out  (pwm_out)
  );

  // Read mux, free of side effects
  always_comb begin
    case (reg_addr)
      REG_COUNT:  reg_rdata = cnt;
      REG_PERIOD: reg_rdata = per_buf;
      REG_DUTY:   reg_rdata = duty_buf;
      default:    reg_rdata = '0;
    endcase
  end

  // R11: duty at or above a nonzero period never lets the output go inactive
  assert_full_duty_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (step && !cnt_wr && per_nxt != '0 && duty_nxt >= per_nxt) |=> (pwm_out == pol_hi));

  // R3: in triangle mode the direction is down only when the count is above zero
  assert_down_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (dir_down && center_mode && per_act != '0 && duty_act <= per_act) |-> (cnt != '0));

endmodule

// File: tb/sim_pwm_chan_counter.sv
module sim_pwm_chan_counter;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick;
  logic         chan_en;
  logic         pol_hi;
  logic         center_mode;
  logic         reg_wr;
  logic [1:0]   reg_addr;
  logic [W-1:0] reg_wdata;
  logic [W-1:0] reg_rdata;
  logic         pwm_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;   // 50 MHz

  pwm_chan_counter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en), .pol_hi(pol_hi),
    .center_mode(center_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  // {center, period, duty, pol, ticks per period, active ticks per period}
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 8'd10,  8'd3,   1'b1, 10'd10,  10'd3},
    {1'b0, 8'd5,   8'd5,   1'b1, 10'd5,   10'd5},
    {1'b0, 8'd7,   8'd9,   1'b0, 10'd7,   10'd7},
    {1'b0, 8'd2,   8'd1,   1'b0, 10'd2,   10'd1},
    {1'b0, 8'd255, 8'd100, 1'b1, 10'd255, 10'd100},
    {1'b1, 8'd4,   8'd2,   1'b1, 10'd8,   10'd3},
    {1'b1, 8'd6,   8'd1,   1'b0, 10'd12,  10'd1},
    {1'b1, 8'd5,   8'd5,   1'b1, 10'd10,  10'd10},
    {1'b1, 8'd3,   8'd2,   1'b0, 10'd6,   10'd3},
    {1'b1, 8'd255, 8'd200, 1'b1, 10'd510, 10'd399}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    int act_n;
    rst_n = 1'b0; tick = 1'b0; chan_en = 1'b1; pol_hi = 1'b1; center_mode = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    rd(2'd0, v); chk("R12 count", v, 0);
    rd(2'd1, v); chk("R12 period buffer", v, 0);
    chk("R12 output inactive", int'(pwm_out), 0);

    // Vector table: one full period per entry
    for (int i = 0; i < NV; i++) begin
      logic [37:0] e;
      int per, len, peak;
      e = VEC[i];
      center_mode = e[37];
      pol_hi      = e[20];
      per  = int'(e[36:29]);
      len  = int'(e[19:10]);
      peak = e[37] ? per : per - 1;
      wr_reg(2'd1, e[36:29]);
      wr_reg(2'd2, e[28:21]);
      wr_reg(2'd0, 8'hFF);
      act_n = 0;
      for (int k = 0; k < len; k++) begin
        if (pwm_out == pol_hi) act_n++;
        if (k == peak) begin
          rd(2'd0, v);
          chk(e[37] ? "R3 peak count" : "R2 peak count", v, peak);
        end
        do_ticks(1);
      end
      chk("R10 active ticks per period", act_n, int'(e[9:0]));
      rd(2'd0, v);
      chk(e[37] ? "R3 wrap to zero" : "R2 wrap to zero", v, 0);
    end

    // R1 / R8: no tick and repeated reads leave the count alone
    center_mode = 1'b0; pol_hi = 1'b1;
    wr_reg(2'd1, 8'd10); wr_reg(2'd2, 8'd3); wr_reg(2'd0, 8'h00);
    do_ticks(4);
    for (int i = 0; i < 5; i++) begin
      rd(2'd0, v);
      @(negedge clk);
    end
    rd(2'd0, v); chk("R1 R8 count held without tick", v, 4);
    rd(2'd2, v); chk("R8 duty buffer readback", v, 3);
    rd(2'd3, v); chk("R8 unused address reads zero", v, 0);

    // R7: disable freezes, enable resumes
    chan_en = 1'b0;
    do_ticks(3);
    rd(2'd0, v); chk("R7 count frozen while disabled", v, 4);
    chk("R7 output held while disabled", int'(pwm_out), 0);
    chan_en = 1'b1;
    do_ticks(1);
    rd(2'd0, v); chk("R7 resume from held count", v, 5);

    // R4 / R6: counter write with arbitrary data, active-low polarity
    pol_hi = 1'b0;
    wr_reg(2'd0, 8'hAB);
    rd(2'd0, v); chk("R4 write clears count", v, 0);
    chk("R6 output active after write", int'(pwm_out), 0);

    // R6: duty 0 is active only until the first tick
    pol_hi = 1'b1;
    wr_reg(2'd2, 8'd0); wr_reg(2'd0, 8'd0);
    chk("R6 active right after write", int'(pwm_out), 1);
    do_ticks(1);
    chk("R10 duty zero inactive after tick", int'(pwm_out), 0);

    // R9 / R5: duty buffer change waits for the period end
    wr_reg(2'd1, 8'd8); wr_reg(2'd2, 8'd2); wr_reg(2'd0, 8'd0);
    do_ticks(3);
    wr_reg(2'd2, 8'd6);
    do_ticks(1);
    chk("R9 old duty kept mid-period", int'(pwm_out), 0);
    do_ticks(4);
    rd(2'd0, v); chk("R2 wrap with period 8", v, 0);
    do_ticks(4);
    chk("R9 new duty after period end", int'(pwm_out), 1);

    // R4: direction reset while falling in triangle mode
    center_mode = 1'b1;
    wr_reg(2'd1, 8'd4); wr_reg(2'd2, 8'd1); wr_reg(2'd0, 8'd0);
    do_ticks(6);
    rd(2'd0, v); chk("R3 falling count", v, 2);
    wr_reg(2'd0, 8'h55);
    do_ticks(1);
    rd(2'd0, v); chk("R4 direction up after write", v, 1);

    // R4: counter write wins over a simultaneous tick
    tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h11;
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R4 write beats tick", v, 0);

    // R11: zero period, constant active, count stays 0
    center_mode = 1'b0; pol_hi = 1'b0;
    wr_reg(2'd1, 8'd0); wr_reg(2'd2, 8'd0); wr_reg(2'd0, 8'd0);
    do_ticks(5);
    rd(2'd0, v); chk("R11 zero period count", v, 0);
    chk("R11 zero period active", int'(pwm_out), 0);

    finish_run();
  end

endmodule